// File: doc/BRIEF.md
# Memory Access Cycle Cost Calculator

This block tells a bus master how many bus cycles a single memory access will occupy. The master presents the access address, the access width and whether the access continues a sequential burst. The block classifies the access by the region code held in address bits 27:24. It then applies the cost rule for that region and returns the cycle count one clock later, together with a single-cycle valid pulse.

There are four kinds of region. Most on-chip regions have a fixed cost. Two regions have a cost that grows for word accesses. The work-RAM region has a cost set by a 4-bit programmable wait value. The external cartridge regions each have their own programmable first-access cost (N) and follow-on cost (S). The cartridge bus is only 16 bits wide, so a word there always costs one extra S transfer. At every 128 KB page boundary the access is forced to the N cost. A DMA engine or CPU bus unit uses the result to stall for the right number of cycles.

Top module: `wsc_cycle_calc`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `rsp_valid` is 0 and `rsp_cycles` is 0.
- R2: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. `rsp_cycles` keeps its value while no request is presented.
- R3: Regions 0, 1, 3, 4 and 7 (`req_addr[27:24]`) cost 1 cycle for every width.
- R4: Regions 5 and 6 cost 1 cycle for a byte or halfword and 2 cycles for a word. Width encoding: `req_size` 0 = byte, 1 = halfword, 2 or 3 = word.
- R5: Region 2 costs 16 minus `cfg_wram_wait`, and twice that for a word.
- R6: Regions 8 to 15 are cartridge regions. The group is g = `req_addr[26:25]`. N is `cfg_cart_n[4g+3:4g]` and S is `cfg_cart_s[4g+3:4g]`. A byte or halfword costs S when `req_seq` is 1 and N when it is 0.
- R7: A word access to a cartridge region costs the R6 value plus S.
- R8: A cartridge access with `req_addr[16:1]` all zero uses N even when `req_seq` is 1. Non-cartridge regions ignore this condition and ignore `req_seq`.
- R9: Address bits above 27 and below bit 1 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W (32) | Access address |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| req_seq | input | 1 | 1 = sequential access, 0 = nonsequential |
| cfg_wram_wait | input | CNT_W (4) | Work-RAM wait setting |
| cfg_cart_n | input | 4*CNT_W (16) | Cartridge first-access cost, one field per group |
| cfg_cart_s | input | 4*CNT_W (16) | Cartridge sequential cost, one field per group |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_cycles | output | CNT_W+2 (6) | Cycle count of the access |

## Verification
A wrong region classification shows up in the very next response: the count is taken from the wrong rule, such as a fixed 1 where a cartridge N value was due. A fault in the cartridge group select or the page-boundary test gives the wrong field from the configuration, one cycle after the request. A fault in the response register either drops the valid pulse or lets `rsp_cycles` move in cycles with no request. The bench sees both in the idle cycle that follows each response.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  // Region classes after address decode
  typedef enum logic [1:0] {
    RC_FAST  = 2'd0,
    RC_VIDEO = 2'd1,
    RC_WRAM  = 2'd2,
    RC_CART  = 2'd3
  } region_class_e;

  localparam int unsigned REGION_W  = 4;
  localparam int unsigned REGION_LSB = 24;
  localparam int unsigned CART_GRPS = 4;
  localparam int unsigned GRP_W     = $clog2(CART_GRPS);
  localparam int unsigned PAGE_MSB  = 16;
endpackage

// File: rtl/wsc_region_decode.sv
module wsc_region_decode
  import wsc_pkg::*;
(
  input  logic [REGION_W-1:0] region,
  output region_class_e       rclass,
  output logic [GRP_W-1:0]    cart_grp
);
  always_comb begin
    unique case (region)
      4'd2:        rclass = RC_WRAM;
      4'd5, 4'd6:  rclass = RC_VIDEO;
      4'd0, 4'd1, 4'd3, 4'd4, 4'd7: rclass = RC_FAST;
      default:     rclass = RC_CART;
    endcase
  end

  // Pairs of cartridge regions share a group: 8/9, 10/11, 12/13, 14/15
  assign cart_grp = region[GRP_W:1];
endmodule

// File: rtl/wsc_fixed_cost.sv
module wsc_fixed_cost
  import wsc_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned CYC_W = CNT_W + 2
) (
  input  region_class_e    rclass,
  input  logic             is_word,
  input  logic [CNT_W-1:0] wram_wait,
  output logic [CYC_W-1:0] cycles
);
  logic [CYC_W-1:0] wram_base;

  assign wram_base = CYC_W'(1 << CNT_W) - CYC_W'(wram_wait);

  always_comb begin
    unique case (rclass)
      RC_VIDEO: cycles = CYC_W'(1) + CYC_W'(is_word);
      RC_WRAM:  cycles = is_word ? (wram_base << 1) : wram_base;
      default:  cycles = CYC_W'(1);
    endcase
  end
endmodule

// File: rtl/wsc_cart_cost.sv
module wsc_cart_cost
  import wsc_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned CYC_W = CNT_W + 2
) (
  input  logic [GRP_W-1:0]           grp,
  input  logic                       page_start,
  input  logic                       seq,
  input  logic                       is_word,
  input  logic [CART_GRPS*CNT_W-1:0] cfg_n,
  input  logic [CART_GRPS*CNT_W-1:0] cfg_s,
  output logic [CYC_W-1:0]           cycles
);
  logic [CNT_W-1:0] n_tab [CART_GRPS];
  logic [CNT_W-1:0] s_tab [CART_GRPS];

  for (genvar g = 0; g < CART_GRPS; g++) begin : g_unpack
    assign n_tab[g] = cfg_n[g*CNT_W +: CNT_W];
    assign s_tab[g] = cfg_s[g*CNT_W +: CNT_W];
  end

  logic             eff_seq;
  logic [CNT_W-1:0] n_sel, s_sel;
  logic [CYC_W-1:0] first_cost;

  assign n_sel      = n_tab[grp];
  assign s_sel      = s_tab[grp];
  assign eff_seq    = seq & ~page_start;
  assign first_cost = eff_seq ? CYC_W'(s_sel) : CYC_W'(n_sel);
  // Narrow bus: a word needs a second, sequential halfword transfer
  assign cycles     = first_cost + (is_word ? CYC_W'(s_sel) : CYC_W'(0));
endmodule

// File: rtl/wsc_cycle_calc.sv
module wsc_cycle_calc
  import wsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned CYC_W = CNT_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [1:0]                 req_size,
  input  logic                       req_seq,
  input  logic [CNT_W-1:0]           cfg_wram_wait,
  input  logic [CART_GRPS*CNT_W-1:0] cfg_cart_n,
  input  logic [CART_GRPS*CNT_W-1:0] cfg_cart_s,
  output logic                       rsp_valid,
  output logic [CYC_W-1:0]           rsp_cycles
);
  region_class_e    rclass;
  logic [GRP_W-1:0] grp;
  logic             is_word;
  logic             page_start;
  logic [CYC_W-1:0] fixed_cyc, cart_cyc, cyc_d;
  logic             valid_d;
  logic             cyc_en;

  assign is_word    = req_size[1];
  assign page_start = (req_addr[PAGE_MSB:1] == '0);

  wsc_region_decode u_dec (
    .region   (req_addr[REGION_LSB +: REGION_W]),
    .rclass   (rclass),
    .cart_grp (grp)
  );

  wsc_fixed_cost #(.CNT_W(CNT_W)) u_fixed (
    .rclass    (rclass),
    .is_word   (is_word),
    .wram_wait (cfg_wram_wait),
    .cycles    (fixed_cyc)
  );

  wsc_cart_cost #(.CNT_W(CNT_W)) u_cart (
    .grp        (grp),
    .page_start (page_start),
    .seq        (req_seq),
    .is_word    (is_word),
    .cfg_n      (cfg_cart_n),
    .cfg_s      (cfg_cart_s),
    .cycles     (cart_cyc)
  );

  // Next-state
  always_comb begin
    valid_d = req_valid;
    cyc_en  = req_valid;
    cyc_d   = (rclass == RC_CART) ? cart_cyc : fixed_cyc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_cycles <= '0;
    end else begin
      rsp_valid <= valid_d;
      if (cyc_en) rsp_cycles <= cyc_d;
    end
  end
endmodule

// File: rtl/wsc_cycle_calc_chk.sv
module wsc_cycle_calc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned CYC_W = CNT_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [CNT_W-1:0]  cfg_wram_wait,
  input logic              rsp_valid,
  input logic [CYC_W-1:0]  rsp_cycles
);
  logic [3:0] rg;
  assign rg = req_addr[27:24];

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (rsp_valid == 1'b0 || $isunknown(rsp_valid));
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_cycles)));

  assert_fast_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (rg == 4'd0 || rg == 4'd1 || rg == 4'd3 || rg == 4'd4 || rg == 4'd7))
    |=> rsp_cycles == CYC_W'(1));

  assert_video_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (rg == 4'd5 || rg == 4'd6))
    |=> rsp_cycles == (CYC_W'(1) + CYC_W'($past(req_size[1]))));

  assert_wram_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rg == 4'd2 && !req_size[1])
    |=> rsp_cycles == (CYC_W'(16) - CYC_W'($past(cfg_wram_wait))));
endmodule

bind wsc_cycle_calc wsc_cycle_calc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .cfg_wram_wait (cfg_wram_wait),
  .rsp_valid     (rsp_valid),
  .rsp_cycles    (rsp_cycles)
);

// File: tb/wsc_cycle_calc_tb_top.sv
`timescale 1ns/1ps
module wsc_cycle_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_seq = 1'b0;
  logic [3:0]  cfg_wram_wait = '0;
  logic [15:0] cfg_cart_n = 16'hA834;
  logic [15:0] cfg_cart_s = 16'h7512;
  logic        rsp_valid;
  logic [5:0]  rsp_cycles;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wsc_cycle_calc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_seq(req_seq), .cfg_wram_wait(cfg_wram_wait),
    .cfg_cart_n(cfg_cart_n), .cfg_cart_s(cfg_cart_s),
    .rsp_valid(rsp_valid), .rsp_cycles(rsp_cycles)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected cost, computed from the written requirements
  function automatic int model(input logic [31:0] a, input logic [1:0] sz, input logic sq);
    int rg, g, n, s, base;
    bit w;
    rg = int'(a[27:24]);
    w  = sz[1];
    if (rg == 2) return (16 - int'(cfg_wram_wait)) * (w ? 2 : 1);
    if (rg == 5 || rg == 6) return w ? 2 : 1;
    if (rg < 8) return 1;
    g = int'(a[26:25]);
    n = int'(cfg_cart_n[g*4 +: 4]);
    s = int'(cfg_cart_s[g*4 +: 4]);
    base = (sq && a[16:1] != 16'd0) ? s : n;
    return base + (w ? s : 0);
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic sq, input string req);
    int exp;
    logic [5:0] held;
    exp = model(a, sz, sq);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_seq = sq;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'hFFFF_FFFF; req_seq = ~sq;
    check(rsp_valid == 1'b1, {req, " R2 valid"}, int'(rsp_valid), 1);
    check(int'(rsp_cycles) == exp, req, int'(rsp_cycles), exp);
    held = rsp_cycles;
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_cycles == held, {req, " R2 hold"}, int'(rsp_cycles), int'(held));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 valid in reset", int'(rsp_valid), 0);
    check(rsp_cycles == 6'd0, "R1 cycles in reset", int'(rsp_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_cycles == 6'd0, "R1 after reset", int'(rsp_cycles), 0);
  endtask

  task automatic t_fast();
    int rl[5] = '{0, 1, 3, 4, 7};
    foreach (rl[i]) begin
      access({4'h0, 4'(rl[i]), 24'h000010}, 2'd2, 1'b0, "R3 fast word");
      access({4'h0, 4'(rl[i]), 24'h000012}, 2'd0, 1'b1, "R3 fast byte");
    end
  endtask

  task automatic t_video();
    access(32'h0500_0000, 2'd0, 1'b1, "R4 video byte page-zero R8");
    access(32'h0500_0040, 2'd1, 1'b0, "R4 video half");
    access(32'h0600_0040, 2'd2, 1'b0, "R4 video word");
    access(32'h0600_0040, 2'd3, 1'b1, "R4 video size3");
  endtask

  task automatic t_wram();
    cfg_wram_wait = 4'd0;
    access(32'h0200_0100, 2'd0, 1'b0, "R5 wram wait0 byte");
    access(32'h0200_0100, 2'd2, 1'b1, "R5 wram wait0 word");
    cfg_wram_wait = 4'd15;
    access(32'h0200_0100, 2'd2, 1'b0, "R5 wram wait15 word");
    cfg_wram_wait = 4'd13;
    access(32'h0200_0000, 2'd1, 1'b1, "R5 wram wait13 half page-zero R8");
    access(32'h0200_0104, 2'd2, 1'b0, "R5 wram wait13 word");
  endtask

  task automatic t_cart();
    for (int r = 8; r < 16; r++) begin
      access({4'h0, 4'(r), 24'h000200}, 2'd1, 1'b1, "R6 cart half seq");
      access({4'h0, 4'(r), 24'h000200}, 2'd0, 1'b0, "R6 cart byte nonseq");
      access({4'h0, 4'(r), 24'h000204}, 2'd2, 1'b1, "R7 cart word seq");
      access({4'h0, 4'(r), 24'h000204}, 2'd2, 1'b0, "R7 cart word nonseq");
    end
  endtask

  task automatic t_page();
    access(32'h0802_0000, 2'd1, 1'b1, "R8 page start half seq");
    access(32'h0A04_0001, 2'd2, 1'b1, "R8 page start word seq");
    access(32'h0800_0002, 2'd1, 1'b1, "R8 bit1 set keeps seq");
    access(32'h0C01_0000, 2'd1, 1'b1, "R8 bit16 set keeps seq");
  endtask

  task automatic t_upper();
    access(32'hF500_0000, 2'd2, 1'b0, "R9 upper bits video");
    access(32'h3000_0000, 2'd2, 1'b0, "R9 upper bits fast");
    access(32'h8C00_0201, 2'd0, 1'b1, "R9 upper bits cart");
    access(32'h0E00_0201, 2'd0, 1'b1, "R9 low bit cart");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0800_0010; req_size = 2'd0; req_seq = 1'b1;
    @(negedge clk);
    check(rsp_valid && int'(rsp_cycles) == 2, "R2 b2b first", int'(rsp_cycles), 2);
    req_addr = 32'h0600_0000; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && int'(rsp_cycles) == 2, "R2 b2b second", int'(rsp_cycles), 2);
    @(negedge clk);
    check(!rsp_valid, "R2 b2b end", int'(rsp_valid), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_video();
    t_wram();
    t_cart();
    t_page();
    t_upper();
    t_back_to_back();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule